// File: doc/BRIEF.md
# Genetic Algorithm Mutation Unit

This block is the mutation stage of a hardware genetic algorithm. A controlling state machine hands it one chromosome produced by crossover. The block returns exactly one chromosome: either a mutated version or the unchanged input. The mutation style is fixed at elaboration by a parameter. In single-bit flip mode one randomly addressed bit is inverted. In mask-XOR mode the chromosome is XORed with a random word. In fresh-word mode the chromosome is replaced by a random word.

Two internal Fibonacci LFSRs supply the randomness. The position LFSR provides the bit index for single-bit flips. The mask LFSR provides the random word and, from its upper bits, a probability word. A mutation happens only when that probability word is at or below the configured rate. Each operation advances both LFSRs exactly once.

A four-state controller sequences every operation. IDLE leaves on an accepted start (IDLE->MUTATE). MUTATE always moves to SETTLE; its closing edge commits the result and steps both LFSRs. SETTLE always moves to REPORT. REPORT always returns to IDLE. `ready_o` is high only in IDLE, and `done_o` only in REPORT.

Top module: `ga_mutation_unit`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `ready_o`=1, `done_o`=0, `chrom_o`=0 and `mutated_o`=0. Both LFSRs load their seed parameters (a seed that truncates to zero loads 1).
- R2: `start_i` is accepted only while `ready_o` is high, and `chrom_i` is captured on that edge. `ready_o` is low from the next cycle until the operation ends. Neither `start_i` nor `chrom_i` has any effect while `ready_o` is low.
- R3: For an operation accepted at edge E, `chrom_o` and `mutated_o` take their new values at E+1. `done_o` is high for exactly the one cycle after E+2. `ready_o` is high again after E+3. Between results `chrom_o` and `mutated_o` hold.
- R4: Each LFSR shifts toward its MSB and feeds the XOR of its tap bits into bit 0. The position LFSR is 2·IDX_W bits wide, where IDX_W = clog2(GENE_W); at 6 bits its taps are bits 5,4. The mask LFSR is GENE_W+RATE_W bits wide; at 12 bits its taps are bits 11,5,3,0. Both step exactly once per operation, at E+1, and that operation's draws use the states before the step.
- R5: The mask is the low GENE_W bits of the mask LFSR, and the probability word p is its upper RATE_W bits. The flip index is the low IDX_W bits of the position LFSR, reduced by GENE_W when it is at or above GENE_W.
- R6: Mutation is applied only when p <= MUT_RATE. Otherwise `chrom_o` equals the captured input and `mutated_o` is 0.
- R7: With METHOD = 0 (single-bit flip), a mutated result is the captured input with the bit at the flip index inverted.
- R8: With METHOD = 1 (mask XOR), a mutated result is the captured input XOR the mask.
- R9: With METHOD = 2 (fresh word), a mutated result equals the mask.
- R10: `mutated_o` is 1 exactly when the gate of R6 opened for the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to mutate `chrom_i` |
| chrom_i | input | GENE_W | Offspring chromosome from crossover |
| ready_o | output | 1 | Unit idle and able to accept `start_i` |
| done_o | output | 1 | One-cycle completion pulse |
| chrom_o | output | GENE_W | Resulting chromosome |
| mutated_o | output | 1 | The last result was mutated |

## Verification
Several properties are checked on every cycle. `ready_o` and `done_o` are never high together, and `done_o` is a single-cycle pulse. An accepted start always drops `ready_o`. Outputs and LFSR states move only on the commit edge, and neither LFSR ever reaches zero. A gated-off result equals the captured input, and in single-bit flip mode a mutated result differs from the input in exactly one bit.

Only the bench's sweeps can show the rest. These are the exact values drawn from each LFSR sequence, the chosen bit index, the mask contents, and the split between mutated and unmutated operations across all inputs. They also include the fact that inputs changed during a busy operation leave the result untouched.

// File: rtl/ga_mut_pkg.sv
package ga_mut_pkg;

    typedef enum logic [1:0] {
        MUT_SINGLE  = 2'd0,
        MUT_MASKED  = 2'd1,
        MUT_UNIFORM = 2'd2
    } mut_method_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MUTATE = 2'd1,
        ST_SETTLE = 2'd2,
        ST_REPORT = 2'd3
    } mut_state_e;

    // Maximal-length feedback tap masks (bit n-1 set for tap n), widths 2..32.
    function automatic logic [31:0] lfsr_taps(input int width);
        logic [31:0] t;
        unique case (width)
            3:  t = 32'h0000_0006;
            4:  t = 32'h0000_000C;
            5:  t = 32'h0000_0014;
            6:  t = 32'h0000_0030;
            7:  t = 32'h0000_0060;
            8:  t = 32'h0000_00B8;
            9:  t = 32'h0000_0110;
            10: t = 32'h0000_0240;
            11: t = 32'h0000_0500;
            12: t = 32'h0000_0829;
            13: t = 32'h0000_100D;
            14: t = 32'h0000_2015;
            15: t = 32'h0000_6000;
            16: t = 32'h0000_D008;
            17: t = 32'h0001_2000;
            18: t = 32'h0002_0400;
            19: t = 32'h0004_0023;
            20: t = 32'h0009_0000;
            21: t = 32'h0014_0000;
            22: t = 32'h0030_0000;
            23: t = 32'h0042_0000;
            24: t = 32'h00E1_0000;
            25: t = 32'h0120_0000;
            26: t = 32'h0200_0023;
            27: t = 32'h0400_0013;
            28: t = 32'h0900_0000;
            29: t = 32'h1400_0000;
            30: t = 32'h2000_0029;
            31: t = 32'h4800_0000;
            32: t = 32'h8020_0003;
            default: t = 32'h0000_0003;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ga_mut_lfsr.sv
module ga_mut_lfsr #(
    parameter int          W    = 12,
    parameter logic [31:0] SEED = 32'h1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] state_o
);
    localparam logic [31:0]  TAPS32  = ga_mut_pkg::lfsr_taps(W);
    localparam logic [W-1:0] TAPS    = TAPS32[W-1:0];
    localparam logic [W-1:0] SEED_W  = SEED[W-1:0];
    localparam logic [W-1:0] START   = (SEED_W == '0) ? W'(1) : SEED_W;

    logic         feedback;
    logic [W-1:0] state_q;

    assign feedback = ^(state_q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= START;
        end else if (adv_i) begin
            state_q <= {state_q[W-2:0], feedback};
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/ga_mut_draw.sv
module ga_mut_draw #(
    parameter int GENE_W   = 8,
    parameter int RATE_W   = 4,
    parameter int MUT_RATE = 7,
    parameter int IDX_W    = 3
) (
    input  logic [IDX_W-1:0]         pos_bits_i,
    input  logic [GENE_W+RATE_W-1:0] mask_state_i,
    output logic [GENE_W-1:0]        mask_o,
    output logic [IDX_W-1:0]         idx_o,
    output logic                     gate_o
);
    localparam logic [RATE_W-1:0] RATE_LIM = RATE_W'(MUT_RATE);
    localparam logic [IDX_W:0]    GENE_LIM = (IDX_W+1)'(GENE_W);

    logic [RATE_W-1:0] prob;
    logic [IDX_W:0]    idx_wide;

    assign mask_o = mask_state_i[GENE_W-1:0];
    assign prob   = mask_state_i[GENE_W+RATE_W-1:GENE_W];
    assign gate_o = (prob <= RATE_LIM);

    always_comb begin
        idx_wide = {1'b0, pos_bits_i};
        if (idx_wide >= GENE_LIM) begin
            idx_wide = idx_wide - GENE_LIM;
        end
        idx_o = idx_wide[IDX_W-1:0];
    end
endmodule

// File: rtl/ga_mut_apply.sv
module ga_mut_apply #(
    parameter int                      GENE_W = 8,
    parameter int                      IDX_W  = 3,
    parameter ga_mut_pkg::mut_method_e METHOD = ga_mut_pkg::MUT_SINGLE
) (
    input  logic [GENE_W-1:0] chrom_i,
    input  logic [GENE_W-1:0] mask_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              gate_i,
    output logic [GENE_W-1:0] result_o
);
    logic [GENE_W-1:0] flip_sel;
    logic [GENE_W-1:0] mutant;

    // One-hot decode of the flip index, one comparator per gene bit.
    for (genvar b = 0; b < GENE_W; b++) begin : g_flip
        assign flip_sel[b] = (idx_i == IDX_W'(b));
    end

    always_comb begin
        unique case (METHOD)
            ga_mut_pkg::MUT_SINGLE:  mutant = chrom_i ^ flip_sel;
            ga_mut_pkg::MUT_MASKED:  mutant = chrom_i ^ mask_i;
            ga_mut_pkg::MUT_UNIFORM: mutant = mask_i;
            default:                 mutant = chrom_i;
        endcase
        result_o = gate_i ? mutant : chrom_i;
    end
endmodule

// File: rtl/ga_mut_ctrl.sv
module ga_mut_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o,
    output logic done_o,
    output logic capture_o,
    output logic commit_o
);
    import ga_mut_pkg::*;

    mut_state_e state_q;
    mut_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_MUTATE;
            ST_MUTATE: state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready_o   = 1'b0;
        done_o    = 1'b0;
        capture_o = 1'b0;
        commit_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o   = 1'b1;
                capture_o = start_i;
            end
            ST_MUTATE: commit_o = 1'b1;
            ST_SETTLE: ;
            ST_REPORT: done_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ga_mutation_unit.sv
module ga_mutation_unit #(
    parameter int                      GENE_W   = 8,
    parameter int                      RATE_W   = 4,
    parameter int                      MUT_RATE = 7,
    parameter ga_mut_pkg::mut_method_e METHOD   = ga_mut_pkg::MUT_SINGLE,
    parameter logic [31:0]             SEED_POS = 32'h0000_0021,
    parameter logic [31:0]             SEED_MSK = 32'h0000_0ACE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [GENE_W-1:0] chrom_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [GENE_W-1:0] chrom_o,
    output logic              mutated_o
);
    localparam int IDX_W = (GENE_W > 2) ? $clog2(GENE_W) : 1;
    localparam int POS_W = 2 * IDX_W;
    localparam int MSK_W = GENE_W + RATE_W;

    logic              capture;
    logic              commit;
    logic [GENE_W-1:0] in_q;
    logic [POS_W-1:0]  pos_q;
    logic [MSK_W-1:0]  msk_q;
    logic [GENE_W-1:0] mask;
    logic [IDX_W-1:0]  idx;
    logic              gate;
    logic [GENE_W-1:0] result;
    logic [GENE_W-1:0] chrom_q;
    logic              mut_q;

    ga_mut_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ready_o   (ready_o),
        .done_o    (done_o),
        .capture_o (capture),
        .commit_o  (commit)
    );

    ga_mut_lfsr #(.W(POS_W), .SEED(SEED_POS)) u_pos_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (commit),
        .state_o (pos_q)
    );

    ga_mut_lfsr #(.W(MSK_W), .SEED(SEED_MSK)) u_msk_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (commit),
        .state_o (msk_q)
    );

    ga_mut_draw #(
        .GENE_W   (GENE_W),
        .RATE_W   (RATE_W),
        .MUT_RATE (MUT_RATE),
        .IDX_W    (IDX_W)
    ) u_draw (
        .pos_bits_i   (pos_q[IDX_W-1:0]),
        .mask_state_i (msk_q),
        .mask_o       (mask),
        .idx_o        (idx),
        .gate_o       (gate)
    );

    ga_mut_apply #(
        .GENE_W (GENE_W),
        .IDX_W  (IDX_W),
        .METHOD (METHOD)
    ) u_apply (
        .chrom_i  (in_q),
        .mask_i   (mask),
        .idx_i    (idx),
        .gate_i   (gate),
        .result_o (result)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else if (capture) begin
            in_q <= chrom_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chrom_q <= '0;
            mut_q   <= 1'b0;
        end else if (commit) begin
            chrom_q <= result;
            mut_q   <= gate;
        end
    end

    assign chrom_o   = chrom_q;
    assign mutated_o = mut_q;
endmodule

// File: rtl/ga_mut_checker.sv
module ga_mut_checker #(
    parameter int                      GENE_W = 8,
    parameter int                      POS_W  = 6,
    parameter int                      MSK_W  = 12,
    parameter ga_mut_pkg::mut_method_e METHOD = ga_mut_pkg::MUT_SINGLE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ready_o,
    input logic              done_o,
    input logic              mutated_o,
    input logic              commit,
    input logic [GENE_W-1:0] chrom_o,
    input logic [GENE_W-1:0] in_q,
    input logic [POS_W-1:0]  pos_q,
    input logic [MSK_W-1:0]  msk_q
);
    localparam bit IS_SINGLE = (METHOD == ga_mut_pkg::MUT_SINGLE);

    p_ready_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && done_o));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !ready_o);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && ready_o));

    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(chrom_o) && $stable(mutated_o)));

    p_step_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(pos_q) && $stable(msk_q)));

    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != '0) && (msk_q != '0));

    p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mutated_o) |-> (chrom_o == in_q));

    p_single_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_SINGLE && done_o && mutated_o) |-> ($countones(chrom_o ^ in_q) == 1));
endmodule

bind ga_mutation_unit ga_mut_checker #(
    .GENE_W (GENE_W),
    .POS_W  (POS_W),
    .MSK_W  (MSK_W),
    .METHOD (METHOD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .mutated_o (mutated_o),
    .commit    (commit),
    .chrom_o   (chrom_o),
    .in_q      (in_q),
    .pos_q     (pos_q),
    .msk_q     (msk_q)
);

// File: tb/ga_mutation_unit_test.sv
module ga_mutation_unit_test;
    localparam int GW   = 8;
    localparam int RW   = 4;
    localparam int RATE = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [GW-1:0] chrom = '0;

    logic          rdy_s, rdy_m, rdy_u;
    logic          dn_s, dn_m, dn_u;
    logic          mt_s, mt_m, mt_u;
    logic [GW-1:0] out_s, out_m, out_u;

    int tests = 0;
    int fails = 0;
    int gate_open_cnt = 0;
    int gate_shut_cnt = 0;

    logic [5:0]  pos_m = 6'h21;
    logic [11:0] msk_m = 12'hACE;

    always #4 clk = ~clk;

    ga_mutation_unit #(.GENE_W(GW), .RATE_W(RW), .MUT_RATE(RATE),
        .METHOD(ga_mut_pkg::MUT_SINGLE), .SEED_POS(32'h21), .SEED_MSK(32'hACE)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chrom_i(chrom),
        .ready_o(rdy_s), .done_o(dn_s), .chrom_o(out_s), .mutated_o(mt_s));

    ga_mutation_unit #(.GENE_W(GW), .RATE_W(RW), .MUT_RATE(RATE),
        .METHOD(ga_mut_pkg::MUT_MASKED), .SEED_POS(32'h21), .SEED_MSK(32'hACE)) uut_msk (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chrom_i(chrom),
        .ready_o(rdy_m), .done_o(dn_m), .chrom_o(out_m), .mutated_o(mt_m));

    ga_mutation_unit #(.GENE_W(GW), .RATE_W(RW), .MUT_RATE(RATE),
        .METHOD(ga_mut_pkg::MUT_UNIFORM), .SEED_POS(32'h21), .SEED_MSK(32'hACE)) uut_uni (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chrom_i(chrom),
        .ready_o(rdy_u), .done_o(dn_u), .chrom_o(out_u), .mutated_o(mt_u));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_ctrl(input string req, input logic r, input logic d);
        chk(req, "ready", {29'd0, rdy_s, rdy_m, rdy_u}, {29'd0, r, r, r});
        chk(req, "done",  {29'd0, dn_s, dn_m, dn_u},    {29'd0, d, d, d});
    endtask

    task automatic do_op(input logic [GW-1:0] value, input logic glitch);
        logic [GW-1:0] mask;
        logic [3:0]    p;
        logic [2:0]    idx;
        logic          gate;
        logic [GW-1:0] e_s, e_m, e_u;
        // R5: draws from the pre-step LFSR states
        mask = msk_m[7:0];
        p    = msk_m[11:8];
        idx  = pos_m[2:0];
        gate = (p <= 4'(RATE));
        e_s  = gate ? (value ^ (GW'(1) << idx)) : value;
        e_m  = gate ? (value ^ mask) : value;
        e_u  = gate ? mask : value;
        if (gate) gate_open_cnt++; else gate_shut_cnt++;
        // R4: each LFSR steps once per operation
        pos_m = {pos_m[4:0], pos_m[5] ^ pos_m[4]};
        msk_m = {msk_m[10:0], msk_m[11] ^ msk_m[5] ^ msk_m[3] ^ msk_m[0]};

        @(negedge clk);
        start = 1'b1;
        chrom = value;
        @(negedge clk);
        // R2: busy now; disturb the inputs, which must be ignored
        check_ctrl("R2", 1'b0, 1'b0);
        start = glitch;
        chrom = ~value;
        @(negedge clk);
        check_ctrl("R3", 1'b0, 1'b0);
        @(negedge clk);
        check_ctrl("R3", 1'b0, 1'b1);
        chk("R7", "single result", {24'd0, out_s}, {24'd0, e_s});
        chk("R8", "masked result", {24'd0, out_m}, {24'd0, e_m});
        chk("R9", "fresh result",  {24'd0, out_u}, {24'd0, e_u});
        chk("R10", "mutated flags", {29'd0, mt_s, mt_m, mt_u}, {29'd0, gate, gate, gate});
        if (!gate) begin
            chk("R6", "pass-through", {24'd0, out_m}, {24'd0, value});
        end
        start = 1'b0;
        @(negedge clk);
        check_ctrl("R3", 1'b1, 1'b0);
        chk("R3", "hold after done", {24'd0, out_s}, {24'd0, e_s});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_ctrl("R1", 1'b1, 1'b0);
        chk("R1", "outputs zero", {5'd0, mt_s, mt_m, mt_u, out_s, out_m, out_u}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_ctrl("R1", 1'b1, 1'b0);
        chk("R1", "outputs zero after release", {5'd0, mt_s, mt_m, mt_u, out_s, out_m, out_u}, 32'd0);
        // R2: idle cycles without start leave the unit waiting
        repeat (2) @(negedge clk);
        check_ctrl("R2", 1'b1, 1'b0);
        for (int v = 0; v < 256; v++) begin
            do_op(GW'(v), v[0]);
        end
        for (int v = 0; v < 64; v++) begin
            do_op(GW'(8'hA5 ^ GW'(v * 3)), 1'b1);
        end
        // R6: the sweep exercised both sides of the probability gate
        chk("R6", "gate opened at least once", {31'd0, gate_open_cnt > 0}, 32'd1);
        chk("R6", "gate shut at least once",   {31'd0, gate_shut_cnt > 0}, 32'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule